// File: doc/BRIEF.md
# Pulse Width Qualifying Trigger

This block watches one sampled digital line and measures each pulse of a chosen polarity in sample-clock cycles. When a pulse meets a programmable width condition, it raises a trigger for exactly one cycle. The condition can be shorter than, longer than, about equal to, inside or outside a width window. The line may carry a single channel or a logic combination of channels. That combining logic sits upstream, and this block sees only the resulting bit.

A pulse starts on the first active sample that follows an inactive sample. Its width is the number of consecutive active samples. Most conditions are judged when the first inactive sample arrives. The longer-than condition is different: it fires while the pulse is still running, as soon as the width passes the bound. The width counter stops at its maximum value. A pulse that is already under way when reset is released is not measured.

Top module: `pw_trigger`

## Requirements
- R1: `trig_o` is 0 during reset and for at least one cycle after any cycle in which it is 1, so every trigger is a single-cycle pulse.
- R2: With `pol_i`=0 the block measures high phases of `src_i`. With `pol_i`=1 it measures low phases.
- R3: A pulse's width W is its count of consecutive active samples. For trailing-judged conditions, `trig_o` is 1 in the cycle after the clock edge that samples the first inactive level.
- R4: Mode 0 (shorter) triggers on the trailing edge when W < `lo_i`.
- R5: Mode 1 (longer) triggers once per pulse, in the cycle after the edge that samples the (`lo_i`+1)-th active sample. It never triggers on a trailing edge, and it never triggers when `lo_i` is 2^WIDTH-1.
- R6: Mode 2 (equal) triggers on the trailing edge when `lo_i`-1 <= W <= `lo_i`+1.
- R7: Mode 3 (inside) triggers on the trailing edge when `lo_i` <= W <= `hi_i`, with both bounds inclusive.
- R8: Mode 4 (outside) triggers on the trailing edge when W < `lo_i` or W > `hi_i`.
- R9: Mode codes 5, 6 and 7 never trigger.
- R10: The width counter saturates at 2^WIDTH-1. A longer pulse is judged as having that width.
- R11: A pulse that is active when reset is released produces no trigger. Measurement begins only after an inactive sample has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 1 | Sampled source line |
| pol_i | input | 1 | 0 = measure high pulses, 1 = measure low pulses |
| mode_i | input | 3 | Width condition: 0 shorter, 1 longer, 2 equal, 3 inside, 4 outside |
| lo_i | input | WIDTH | Lower width bound (the only bound for modes 0 to 2) |
| hi_i | input | WIDTH | Upper width bound for modes 3 and 4 |
| trig_o | output | 1 | One-cycle trigger |

## Verification
The assertions assume that `pol_i`, `mode_i`, `lo_i` and `hi_i` stay constant while a pulse is being measured. They also assume that `hi_i` >= `lo_i` whenever a window mode is selected. The stimulus meets these assumptions in two ways. It changes settings only at the start of an idle gap, together with a source level that is inactive under the new polarity. It also draws `hi_i` at or above `lo_i`. Random pulses with random widths and gaps are mixed with directed cases at the exact bound edges, in saturation and across reset release.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PW_SHORTER = 3'd0,
        PW_LONGER  = 3'd1,
        PW_EQUAL   = 3'd2,
        PW_INSIDE  = 3'd3,
        PW_OUTSIDE = 3'd4
    } pw_mode_e;

    // per-sample event classification of the normalized line
    typedef struct packed {
        logic lead;   // first active sample after an inactive one
        logic hold;   // active sample continuing a measured pulse
        logic trail;  // first inactive sample ending a measured pulse
    } pw_evt_t;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        return m <= MODE_W'(PW_OUTSIDE);
    endfunction

endpackage

// File: rtl/pw_phase.sv
module pw_phase
    import pw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    act_i,
    output pw_evt_t evt_o,
    output logic    in_pulse_o
);
    logic idle_q;   // previous sample was inactive
    logic in_q;     // inside a measured pulse

    always_comb begin
        evt_o.lead  = act_i & idle_q;
        evt_o.hold  = act_i & in_q;
        evt_o.trail = ~act_i & in_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b0;
            in_q   <= 1'b0;
        end else begin
            idle_q <= ~act_i;
            in_q   <= act_i & (idle_q | in_q);
        end
    end

    assign in_pulse_o = in_q;
endmodule

// File: rtl/pw_width.sv
module pw_width #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lead_i,
    input  logic         hold_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (lead_i) begin
            cnt_q <= W'(1);
        end else if (hold_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pw_judge.sv
module pw_judge
    import pw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pw_evt_t           evt_i,
    input  logic [W-1:0]      cnt_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [W-1:0]      lo_i,
    input  logic [W-1:0]      hi_i,
    output logic              trig_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W:0] w_ext, lo_ext, w_p1, lo_p1;
    logic       in_window, trail_ok, over_ok, fire;
    logic       trig_q;

    always_comb begin
        w_ext     = {1'b0, cnt_i};
        lo_ext    = {1'b0, lo_i};
        w_p1      = w_ext + (W+1)'(1);
        lo_p1     = lo_ext + (W+1)'(1);
        in_window = (cnt_i >= lo_i) && (cnt_i <= hi_i);

        trail_ok = 1'b0;
        if (mode_known(mode_i)) begin
            case (pw_mode_e'(mode_i))
                PW_SHORTER: trail_ok = cnt_i < lo_i;
                PW_EQUAL:   trail_ok = (w_p1 >= lo_ext) && (w_ext <= lo_p1);
                PW_INSIDE:  trail_ok = in_window;
                PW_OUTSIDE: trail_ok = ~in_window;
                default:    trail_ok = 1'b0;
            endcase
        end

        // width passes lo_i on this sample
        over_ok = (evt_i.lead && lo_i == '0) ||
                  (evt_i.hold && cnt_i == lo_i && cnt_i != CNT_MAX);

        if (mode_i == MODE_W'(PW_LONGER))
            fire = over_ok;
        else
            fire = evt_i.trail & trail_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= fire;
    end

    assign trig_o = trig_q;
endmodule

// File: rtl/pw_trigger.sv
module pw_trigger
    import pw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         src_i,
    input  logic         pol_i,
    input  logic [2:0]   mode_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic         trig_o
);
    logic         act;
    pw_evt_t      evt;
    logic         in_pulse;
    logic [W-1:0] width_cnt;

    assign act = src_i ^ pol_i;

    pw_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .act_i      (act),
        .evt_o      (evt),
        .in_pulse_o (in_pulse)
    );

    pw_width #(.W(W)) u_width (
        .clk    (clk),
        .rst    (rst),
        .lead_i (evt.lead),
        .hold_i (evt.hold),
        .cnt_o  (width_cnt)
    );

    pw_judge #(.W(W)) u_judge (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .cnt_i  (width_cnt),
        .mode_i (mode_i),
        .lo_i   (lo_i),
        .hi_i   (hi_i),
        .trig_o (trig_o)
    );
endmodule

// File: rtl/pw_trigger_chk.sv
module pw_trigger_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         src_i,
    input logic         pol_i,
    input logic [2:0]   mode_i,
    input logic         trig_o,
    input logic         in_pulse,
    input logic [W-1:0] width_cnt
);
    logic act;
    logic idle_seen;

    assign act = src_i ^ pol_i;

    always_ff @(posedge clk) begin
        if (rst) idle_seen <= 1'b0;
        else     idle_seen <= idle_seen | ~act;
    end

    a_r1_one_cycle: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    a_r9_bad_mode_silent: assert property (@(posedge clk) disable iff (rst)
        (mode_i > 3'd4) |=> !trig_o);

    a_r5_longer_quiet_on_trail: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd1 && in_pulse && !act) |=> !trig_o);

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (in_pulse && act) |=> (width_cnt >= $past(width_cnt)));

    a_r11_needs_idle: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> idle_seen);
endmodule

bind pw_trigger pw_trigger_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .pol_i     (pol_i),
    .mode_i    (mode_i),
    .trig_o    (trig_o),
    .in_pulse  (in_pulse),
    .width_cnt (width_cnt)
);

// File: tb/tb_pw_trigger.sv
module tb_pw_trigger;
    localparam int W      = 8;
    localparam int MAXW   = (1 << W) - 1;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         src_i = 1'b0;
    logic         pol_i = 1'b0;
    logic [2:0]   mode_i = 3'd0;
    logic [W-1:0] lo_i = '0;
    logic [W-1:0] hi_i = '0;
    logic         trig_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    pw_trigger #(.W(W)) dut (
        .clk(clk), .rst(rst), .src_i(src_i), .pol_i(pol_i),
        .mode_i(mode_i), .lo_i(lo_i), .hi_i(hi_i), .trig_o(trig_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit trail_ok(input int m, input int l, input int h, input int w);
        int wm;
        wm = (w > MAXW) ? MAXW : w;   // R10 saturation
        case (m)
            0: return wm < l;                          // R4
            2: return (wm + 1 >= l) && (wm <= l + 1);  // R6
            3: return (wm >= l) && (wm <= h);          // R7
            4: return !((wm >= l) && (wm <= h));       // R8
            default: return 1'b0;                      // R9
        endcase
    endfunction

    // idle for gap samples, active for w samples, then check every cycle
    task automatic run_pulse(input logic p, input int m, input int l, input int h,
                             input int w, input int gap, input string req);
        bit hit;
        int at;
        bit bad;
        bit exp_v;
        logic got_v;
        int bad_cyc;
        bad = 1'b0; got_v = 1'b0; exp_v = 1'b0; bad_cyc = 0;
        if (m == 1) begin
            hit = (w > l) && (l < MAXW);   // R5
            at  = gap + l;
        end else begin
            hit = trail_ok(m, l, h, w);    // R3
            at  = gap + w;
        end
        for (int k = 0; k <= gap + w + 1; k++) begin
            @(negedge clk);
            if (k > 0) begin
                if (trig_o !== (hit && (k - 1 == at)) && !bad) begin
                    bad = 1'b1; got_v = trig_o; exp_v = hit && (k - 1 == at);
                    bad_cyc = k - 1;
                end
            end
            pol_i  = p;
            mode_i = 3'(m);
            lo_i   = W'(l);
            hi_i   = W'(h);
            src_i  = ((k >= gap) && (k < gap + w)) ^ p;
        end
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: pol=%0d mode=%0d lo=%0d hi=%0d w=%0d sample %0d got trig=%0d expected %0d",
                     req, p, m, l, h, w, bad_cyc, got_v, exp_v);
        end
    endtask

    task automatic check_quiet(input int n, input string req);
        bit bad;
        bad = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (trig_o !== 1'b0) bad = 1'b1;
        end
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: got trig=1 expected 0", req);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        int p, m, l, h, w, g;
        seed = 32'h5eed_0042;
        void'($urandom(seed));

        // R1: reset state, R11: pulse active across reset release
        pol_i = 1'b0; mode_i = 3'd1; lo_i = '0; hi_i = '0; src_i = 1'b1;
        check_quiet(4, "R1");
        @(negedge clk); rst = 1'b0;
        check_quiet(6, "R11");
        @(negedge clk); src_i = 1'b0;
        check_quiet(3, "R11");

        // directed boundaries
        run_pulse(0, 0, 5, 0, 4, 2, "R4");
        run_pulse(0, 0, 5, 0, 5, 2, "R4");
        run_pulse(0, 0, 0, 0, 1, 2, "R4");
        run_pulse(0, 1, 0, 0, 3, 2, "R5");
        run_pulse(0, 1, 4, 0, 4, 2, "R5");
        run_pulse(0, 1, 4, 0, 5, 2, "R5");
        run_pulse(1, 1, 3, 0, 9, 3, "R5");
        run_pulse(0, 2, 6, 0, 4, 2, "R6");
        run_pulse(0, 2, 6, 0, 5, 2, "R6");
        run_pulse(0, 2, 6, 0, 7, 2, "R6");
        run_pulse(0, 2, 6, 0, 8, 2, "R6");
        run_pulse(0, 3, 3, 7, 3, 2, "R7");
        run_pulse(0, 3, 3, 7, 7, 2, "R7");
        run_pulse(0, 3, 3, 7, 2, 2, "R7");
        run_pulse(0, 3, 3, 7, 8, 2, "R7");
        run_pulse(0, 4, 3, 7, 2, 2, "R8");
        run_pulse(0, 4, 3, 7, 5, 2, "R8");
        run_pulse(0, 4, 3, 7, 8, 2, "R8");
        run_pulse(1, 3, 2, 4, 3, 2, "R2");
        run_pulse(1, 0, 4, 0, 2, 1, "R2");
        run_pulse(0, 5, 0, 9, 3, 2, "R9");
        run_pulse(0, 6, 0, 0, 2, 2, "R9");
        run_pulse(0, 7, 9, 9, 2, 2, "R9");
        run_pulse(0, 3, 250, 255, 300, 2, "R10");
        run_pulse(0, 2, 255, 0, 300, 2, "R10");
        run_pulse(0, 1, 255, 0, 300, 2, "R10");
        run_pulse(0, 4, 1, 10, 300, 2, "R10");

        // constrained random pulses
        for (int i = 0; i < 200; i++) begin
            p = int'($urandom_range(1, 0));
            m = int'($urandom_range(9, 0));
            if (m > 7) m = m - 5;
            l = int'($urandom_range(20, 0));
            h = l + int'($urandom_range(10, 0));
            w = int'($urandom_range(35, 1));
            g = int'($urandom_range(4, 1));
            run_pulse(p[0], m, l, h, w, g, "R3");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule